// File: doc/BRIEF.md
# Shadowed Register with Change-Driven Persistence

This block is an 8-bit user register with an active-low output enable. A background controller keeps a slow persistent shadow copy of the register's settled value. The capture behaviour is fixed at build time. In edge mode the register loads on a rising capture strobe. In level mode it is transparent while the strobe is high and holds once the strobe drops. The capture strobe is sampled on the system clock, so all state lives in one clock domain.

The controller compares the committed value with its copy of the shadow cells one bit at a time. When any bit differs, it starts one timed write on the shadow-cell port. That write carries the full committed value together with a mask of the differing bits, so unchanged cells are left alone. A single write is in flight at a time. Changes that arrive while a write is busy wait until it completes, and the comparison then runs again. Under a burst, intermediate values may be skipped, but the shadow always ends on the last committed value. A supply-status input blocks user loads and new shadow writes, but it never cuts short a write that is already running.

Top module: `shreg_nv`

## Requirements
- R1: In edge mode, `q_o` takes the value of `data_i` at the first clock edge where `cap_i` is sampled 1 after being sampled 0. It does not change while `cap_i` stays low, whatever `data_i` does.
- R2: In level mode, the register takes `data_i` at every clock edge where `cap_i` is sampled 1, and holds its value at every edge where `cap_i` is sampled 0.
- R3: With `oe_ni` high, `q_o` is high impedance. The register still loads, and the loaded value appears on `q_o` once `oe_ni` returns low.
- R4: A shadow write starts only when the committed value differs from the shadow copy. `sh_data_o` carries the committed value, and bit i of `sh_mask_o` is 1 exactly when bit i differs. Reloading the value already shadowed starts no write.
- R5: In level mode, values taken while the strobe is high are never written. The candidate is the value held at the edge where `cap_i` is first sampled 0, and the write starts one edge later.
- R6: `sh_busy_o` stays high for exactly `WR_CYCLES` clock cycles per write. `sh_data_o` and `sh_mask_o` stay stable throughout, and at least one idle cycle separates two writes.
- R7: While `pwr_ok_i` is sampled 0, no user load occurs and no new write starts. A write already running completes, and a pending difference is written once `pwr_ok_i` returns.
- R8: When loads arrive faster than writes complete, some intermediate values are skipped. Once loads stop, the shadow converges to the last committed value.
- R9: Asynchronous reset clears the register, the shadow copy, `sh_busy_o`, `sh_data_o` and `sh_mask_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| data_i | input | WIDTH | Data to capture |
| cap_i | input | 1 | Capture strobe: a rising edge in edge mode, a high level in level mode |
| oe_ni | input | 1 | Output enable, active low |
| pwr_ok_i | input | 1 | Supply status; 0 blocks loads and new writes |
| q_o | output | WIDTH | Register value, high impedance when `oe_ni` is high |
| sh_busy_o | output | 1 | Shadow write in flight; the cells take data under the mask while high |
| sh_data_o | output | WIDTH | Value being written to the shadow cells |
| sh_mask_o | output | WIDTH | Bits of `sh_data_o` that the cells accept |

## Verification
The bench builds two copies with `WR_CYCLES` set to 5: one in edge mode and one in level mode. They share the data, output-enable and supply inputs. The short write time lets a burst of strobes spaced two cycles apart outrun the writer, which brings value skipping and final convergence within reach. It also lets a supply drop land in the middle of a running write. The level-mode copy opens its transparent phase with values that differ from the final held value. One open phase closes on the value already shadowed, which shows that transparent activity alone produces no write.

// File: rtl/shreg_pkg.sv
`timescale 1ns/1ps
package shreg_pkg;
  typedef enum logic {
    MODE_EDGE  = 1'b0,
    MODE_LEVEL = 1'b1
  } cap_mode_e;
endpackage

// File: rtl/shreg_capture.sv
`timescale 1ns/1ps
module shreg_capture
  import shreg_pkg::*;
#(
  parameter int        WIDTH = 8,
  parameter cap_mode_e MODE  = MODE_EDGE
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cap_i,
  input  logic             pwr_ok_i,
  input  logic [WIDTH-1:0] data_i,
  output logic [WIDTH-1:0] user_o,
  output logic [WIDTH-1:0] commit_o
);

  logic             cap_q;
  logic             load_en;
  logic [WIDTH-1:0] user_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cap_q <= 1'b0;
    else         cap_q <= cap_i;
  end

  generate
    if (MODE == MODE_EDGE) begin : g_edge
      assign load_en  = pwr_ok_i & cap_i & ~cap_q;
      assign commit_o = user_q;
    end else begin : g_level
      logic [WIDTH-1:0] commit_q;
      logic             close;
      assign load_en = pwr_ok_i & cap_i;
      assign close   = pwr_ok_i & cap_q & ~cap_i;
      // only the value held after the strobe drops is a write candidate
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)    commit_q <= '0;
        else if (close) commit_q <= user_q;
      end
      assign commit_o = commit_q;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      user_q <= '0;
    else if (load_en) user_q <= data_i;
  end

  assign user_o = user_q;

endmodule

// File: rtl/shreg_writer.sv
`timescale 1ns/1ps
module shreg_writer #(
  parameter int WIDTH     = 8,
  parameter int WR_CYCLES = 125
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pwr_ok_i,
  input  logic [WIDTH-1:0] commit_i,
  output logic             busy_o,
  output logic [WIDTH-1:0] data_o,
  output logic [WIDTH-1:0] mask_o
);

  localparam int CNT_W = (WR_CYCLES > 1) ? $clog2(WR_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WR_CYCLES - 1);

  logic             busy_q;
  logic [CNT_W-1:0] cnt_q;
  logic [WIDTH-1:0] data_q, mask_q, shadow_q, diff;
  logic             done, start;

  assign done  = busy_q && (cnt_q == CNT_LAST);
  assign start = !busy_q && pwr_ok_i && (|diff);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      data_q <= '0;
      mask_q <= '0;
    end else if (busy_q) begin
      // an in-flight write always runs to the end, supply state ignored
      if (done) begin
        busy_q <= 1'b0;
        cnt_q  <= '0;
      end else begin
        cnt_q  <= cnt_q + 1'b1;
      end
    end else if (start) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
      data_q <= commit_i;
      mask_q <= diff;
    end
  end

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    assign diff[b] = commit_i[b] ^ shadow_q[b];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                 shadow_q[b] <= 1'b0;
      else if (done && mask_q[b])  shadow_q[b] <= data_q[b];
    end
  end

  assign busy_o = busy_q;
  assign data_o = data_q;
  assign mask_o = mask_q;

endmodule

// File: rtl/shreg_nv.sv
`timescale 1ns/1ps
module shreg_nv
  import shreg_pkg::*;
#(
  parameter int        WIDTH     = 8,
  parameter int        WR_CYCLES = 125,
  parameter cap_mode_e MODE      = MODE_EDGE
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] data_i,
  input  logic             cap_i,
  input  logic             oe_ni,
  input  logic             pwr_ok_i,
  output logic [WIDTH-1:0] q_o,
  output logic             sh_busy_o,
  output logic [WIDTH-1:0] sh_data_o,
  output logic [WIDTH-1:0] sh_mask_o
);

  logic [WIDTH-1:0] user_q;
  logic [WIDTH-1:0] commit_q;

  shreg_capture #(
    .WIDTH (WIDTH),
    .MODE  (MODE)
  ) i_capture (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cap_i    (cap_i),
    .pwr_ok_i (pwr_ok_i),
    .data_i   (data_i),
    .user_o   (user_q),
    .commit_o (commit_q)
  );

  shreg_writer #(
    .WIDTH     (WIDTH),
    .WR_CYCLES (WR_CYCLES)
  ) i_writer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .pwr_ok_i (pwr_ok_i),
    .commit_i (commit_q),
    .busy_o   (sh_busy_o),
    .data_o   (sh_data_o),
    .mask_o   (sh_mask_o)
  );

  assign q_o = oe_ni ? {WIDTH{1'bz}} : user_q;

endmodule

// File: rtl/shreg_nv_chk.sv
`timescale 1ns/1ps
module shreg_nv_chk
  import shreg_pkg::*;
#(
  parameter int        WIDTH     = 8,
  parameter int        WR_CYCLES = 125,
  parameter cap_mode_e MODE      = MODE_EDGE
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cap_i,
  input logic             pwr_ok_i,
  input logic             sh_busy_o,
  input logic [WIDTH-1:0] sh_data_o,
  input logic [WIDTH-1:0] sh_mask_o,
  input logic [WIDTH-1:0] user_q,
  input logic [WIDTH-1:0] commit_q
);

  int run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        run_q <= 0;
    else if (sh_busy_o) run_q <= run_q + 1;
    else                run_q <= 0;
  end

  assert_hold_no_cap_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cap_i |=> $stable(user_q));

  assert_no_load_pwr_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr_ok_i |=> $stable(user_q));

  assert_no_start_pwr_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pwr_ok_i && !sh_busy_o) |=> !sh_busy_o);

  assert_mask_nonzero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sh_busy_o) |-> (sh_mask_o != '0));

  assert_data_is_commit_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sh_busy_o) |-> (sh_data_o == $past(commit_q)));

  assert_fields_stable_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sh_busy_o && $past(sh_busy_o)) |-> ($stable(sh_data_o) && $stable(sh_mask_o)));

  assert_write_len_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sh_busy_o) |-> (run_q == WR_CYCLES));

  generate
    if (MODE == MODE_LEVEL) begin : g_level_chk
      assert_no_commit_open_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cap_i |=> $stable(commit_q));
    end
  endgenerate

endmodule

bind shreg_nv shreg_nv_chk #(
  .WIDTH     (WIDTH),
  .WR_CYCLES (WR_CYCLES),
  .MODE      (MODE)
) i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .cap_i     (cap_i),
  .pwr_ok_i  (pwr_ok_i),
  .sh_busy_o (sh_busy_o),
  .sh_data_o (sh_data_o),
  .sh_mask_o (sh_mask_o),
  .user_q    (user_q),
  .commit_q  (commit_q)
);

// File: tb/test_shreg_nv.sv
`timescale 1ns/1ps
module test_shreg_nv;
  localparam int W  = 8;
  localparam int WR = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [W-1:0] data_d = '0;
  logic cap_e = 1'b0, cap_l = 1'b0, oe_n = 1'b0, pwr_ok = 1'b1;
  wire  [W-1:0] q_e, q_l;
  logic         busy [2];
  logic [W-1:0] sdat [2];
  logic [W-1:0] smsk [2];

  for (genvar b = 0; b < W; b++) begin : g_pu
    pullup (q_e[b]);
    pullup (q_l[b]);
  end

  shreg_nv #(.WIDTH(W), .WR_CYCLES(WR), .MODE(shreg_pkg::MODE_EDGE)) i_shreg_nv (
    .clk_i(clk), .rst_ni(rst_n), .data_i(data_d), .cap_i(cap_e), .oe_ni(oe_n),
    .pwr_ok_i(pwr_ok), .q_o(q_e), .sh_busy_o(busy[0]), .sh_data_o(sdat[0]),
    .sh_mask_o(smsk[0]));

  shreg_nv #(.WIDTH(W), .WR_CYCLES(WR), .MODE(shreg_pkg::MODE_LEVEL)) i_shreg_nv_lvl (
    .clk_i(clk), .rst_ni(rst_n), .data_i(data_d), .cap_i(cap_l), .oe_ni(oe_n),
    .pwr_ok_i(pwr_ok), .q_o(q_l), .sh_busy_o(busy[1]), .sh_data_o(sdat[1]),
    .sh_mask_o(smsk[1]));

  int checks = 0, fails = 0;
  logic [15:0] exp0 [$];
  logic [15:0] exp1 [$];
  logic [W-1:0] shm [2];
  logic [W-1:0] expsh [2];
  bit   burst [2];
  int   nwr [2];
  int   runl [2];
  logic bprev [2];

  task automatic chk(input bit ok, input string tag, input logic [15:0] act,
                     input logic [15:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // monitor: pops expected writes, models the shadow cells, checks write length
  always @(negedge clk) begin
    for (int k = 0; k < 2; k++) begin
      if (!rst_n) begin
        bprev[k] = 1'b0;
        runl[k]  = 0;
        shm[k]   = '0;
      end else begin
        if (busy[k] && !bprev[k]) begin
          logic [15:0] e;
          runl[k] = 1;
          nwr[k]++;
          if (!burst[k]) begin
            if ((k == 0 && exp0.size() == 0) || (k == 1 && exp1.size() == 0)) begin
              checks++;
              fails++;
              $display("FAIL R4 inst%0d unexpected write act=%h exp=none", k,
                       {sdat[k], smsk[k]});
            end else begin
              if (k == 0) e = exp0.pop_front();
              else        e = exp1.pop_front();
              chk({sdat[k], smsk[k]} == e, "R4 write data/mask", {sdat[k], smsk[k]}, e);
            end
          end
          for (int b = 0; b < W; b++) if (smsk[k][b]) shm[k][b] = sdat[k][b];
        end else if (busy[k]) begin
          runl[k]++;
        end else if (bprev[k]) begin
          chk(runl[k] == WR, "R6 write length", 16'(runl[k]), 16'(WR));
        end
        bprev[k] = busy[k];
      end
    end
  end

  task automatic load_e(input logic [W-1:0] v, input bit push);
    if (push && v != expsh[0]) begin
      exp0.push_back({v, v ^ expsh[0]});
      expsh[0] = v;
    end
    @(posedge clk); #1 data_d = v; cap_e = 1'b1;
    @(posedge clk); #1 cap_e = 1'b0;
  endtask

  task automatic count_busy(input int k, input int n, output int hi);
    hi = 0;
    repeat (n) begin
      @(negedge clk);
      if (busy[k]) hi++;
    end
  endtask

  task automatic settle();
    repeat (WR + 6) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog act=running exp=done");
    finish_run();
  end

  initial begin
    int hi;
    int w0;
    logic [W-1:0] v;
    expsh[0] = '0; expsh[1] = '0;
    burst[0] = 1'b0; burst[1] = 1'b0;
    nwr[0] = 0; nwr[1] = 0;

    // R9 reset state
    repeat (3) @(negedge clk);
    chk(q_e == 8'h00, "R9 reset q edge", {8'h0, q_e}, 16'h0);
    chk(q_l == 8'h00, "R9 reset q level", {8'h0, q_l}, 16'h0);
    chk(!busy[0] && !busy[1], "R9 reset busy", {15'h0, busy[0] | busy[1]}, 16'h0);
    chk(smsk[0] == 8'h00 && sdat[0] == 8'h00, "R9 reset write fields",
        {sdat[0], smsk[0]}, 16'h0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1 edge load and hold
    load_e(8'h5A, 1'b1);
    @(negedge clk);
    chk(q_e == 8'h5A, "R1 edge load", {8'h0, q_e}, 16'h5A);
    data_d = 8'hFF;
    repeat (3) @(negedge clk);
    chk(q_e == 8'h5A, "R1 hold with strobe low", {8'h0, q_e}, 16'h5A);
    settle();
    chk(shm[0] == 8'h5A, "R4 shadow after write", {8'h0, shm[0]}, 16'h5A);

    // R4 single-bit change, then reload of the same value
    load_e(8'h5B, 1'b1);
    settle();
    chk(shm[0] == 8'h5B, "R4 one-bit update", {8'h0, shm[0]}, 16'h5B);
    load_e(8'h5B, 1'b1);
    count_busy(0, WR + 6, hi);
    chk(hi == 0, "R4 no write on equal value", 16'(hi), 16'h0);

    // R3 output enable
    @(negedge clk) oe_n = 1'b1;
    @(negedge clk);
    chk(q_e == 8'hFF, "R3 outputs released", {8'h0, q_e}, 16'hFF);
    load_e(8'hC3, 1'b1);
    @(negedge clk);
    chk(q_e == 8'hFF, "R3 released during load", {8'h0, q_e}, 16'hFF);
    settle();
    oe_n = 1'b0;
    @(negedge clk);
    chk(q_e == 8'hC3, "R3 loaded value after enable", {8'h0, q_e}, 16'hC3);

    // R7 supply drop during a running write
    load_e(8'hA5, 1'b1);
    @(posedge clk); #1 pwr_ok = 1'b0;
    @(negedge clk);
    chk(busy[0] == 1'b1, "R7 write running at drop", {15'h0, busy[0]}, 16'h1);
    settle();
    chk(shm[0] == 8'hA5, "R7 in-flight write completes", {8'h0, shm[0]}, 16'hA5);
    load_e(8'h3C, 1'b0);
    @(negedge clk);
    chk(q_e == 8'hA5, "R7 load blocked", {8'h0, q_e}, 16'hA5);
    count_busy(0, WR + 6, hi);
    chk(hi == 0, "R7 no write while supply low", 16'(hi), 16'h0);
    pwr_ok = 1'b1;
    count_busy(0, WR + 6, hi);
    chk(hi == 0, "R7 blocked load leaves nothing pending", 16'(hi), 16'h0);

    // R7 pending difference held until supply returns
    load_e(8'h0F, 1'b1);
    pwr_ok = 1'b0;
    count_busy(0, 2 * WR, hi);
    chk(hi == 0, "R7 start blocked", 16'(hi), 16'h0);
    chk(q_e == 8'h0F, "R7 load before drop kept", {8'h0, q_e}, 16'h0F);
    pwr_ok = 1'b1;
    settle();
    chk(shm[0] == 8'h0F, "R7 pending write after return", {8'h0, shm[0]}, 16'h0F);

    // R8 burst faster than the writer
    burst[0] = 1'b1;
    w0 = nwr[0];
    v  = 8'h00;
    for (int i = 0; i < 10; i++) begin
      v = 8'h10 + 8'(i * 8'h13);
      load_e(v, 1'b0);
    end
    repeat (2 * (WR + 6)) @(negedge clk);
    burst[0] = 1'b0;
    expsh[0] = v;
    chk(shm[0] == v, "R8 shadow converges", {8'h0, shm[0]}, {8'h0, v});
    chk(q_e == v, "R8 last value on outputs", {8'h0, q_e}, {8'h0, v});
    chk((nwr[0] - w0) < 10, "R8 intermediate values skipped", 16'(nwr[0] - w0), 16'd10);
    chk(!busy[0], "R8 writer idle after catch-up", {15'h0, busy[0]}, 16'h0);

    // R2 / R5 level mode
    @(negedge clk) begin data_d = 8'h11; cap_l = 1'b1; end
    @(posedge clk); @(negedge clk);
    chk(q_l == 8'h11, "R2 transparent follow", {8'h0, q_l}, 16'h11);
    data_d = 8'h22;
    @(posedge clk); @(negedge clk);
    chk(q_l == 8'h22, "R2 transparent follow 2", {8'h0, q_l}, 16'h22);
    data_d = 8'h33;
    @(posedge clk); @(negedge clk);
    chk(q_l == 8'h33, "R2 transparent follow 3", {8'h0, q_l}, 16'h33);
    chk(!busy[1], "R5 no write while open", {15'h0, busy[1]}, 16'h0);
    exp1.push_back({8'h33, 8'h33 ^ expsh[1]});
    expsh[1] = 8'h33;
    cap_l = 1'b0;
    data_d = 8'h44;
    @(posedge clk); @(negedge clk);
    chk(q_l == 8'h33, "R2 hold after close", {8'h0, q_l}, 16'h33);
    settle();
    chk(shm[1] == 8'h33, "R5 held value written", {8'h0, shm[1]}, 16'h33);

    @(negedge clk) begin data_d = 8'h7E; cap_l = 1'b1; end
    @(posedge clk); @(negedge clk);
    chk(q_l == 8'h7E, "R2 reopen follow", {8'h0, q_l}, 16'h7E);
    data_d = 8'h33;
    @(posedge clk); @(negedge clk);
    cap_l = 1'b0;
    count_busy(1, WR + 6, hi);
    chk(hi == 0, "R5 transparent value never written", 16'(hi), 16'h0);
    chk(shm[1] == 8'h33, "R5 shadow unchanged", {8'h0, shm[1]}, 16'h33);
    chk(q_e == v, "R2 edge copy untouched by level test", {8'h0, q_e}, {8'h0, v});

    finish_run();
  end

endmodule